// File: doc/BRIEF.md
# Contactor Actuation Delay Model

This block stands in for one electromechanical contactor when a power-system controller is tested in simulation or on an FPGA. The controller drives a single command bit (1 asks for closed, 0 asks for open) and gets back a status bit. The status does not follow at once. It follows after a programmable number of clock cycles, and the open and close directions each have their own delay. A delay value is accepted only if it lies inside the legal window for its direction. A value outside the window is refused and raises a configuration error.

While the contactor is opening, a renewed close command cancels the pending open and the contact stays closed. A close that has started is not cancelled: it completes, and the model then reacts to whatever the command is at that point.

An independent monitor watches a status bit supplied from outside, which may be this model's own status or a real device. It flags a change that arrives sooner than the minimum for its direction, a change that has not arrived by the maximum, and a change that nobody asked for.

Top module: `contactor_model`

## Requirements
- R1: While no transition is pending and the command equals the status, the status keeps its value at the next clock edge. The status changes only when a transition was pending in the cycle before.
- R2: Status encoding is 1 for closed and 0 for open. A close starts at the edge that samples a command of 1 against an open status. The status becomes 1 at exactly the programmed close-delay count of edges later. Dropping the command during a pending close does not stop it.
- R3: An open starts at the edge that samples a command of 0 against a closed status. The status becomes 0 at exactly the programmed open-delay count of edges later.
- R4: If the command returns to 1 while an open is pending, the open is abandoned at that edge. The status stays 1 and the busy output drops.
- R5: After reset the status is 0 and busy, the configuration error and both monitor flags are 0. The close delay is CLOSE_MIN and the open delay is OPEN_MIN.
- R6: A load pulse with select 0 writes the close delay, and with select 1 writes the open delay. An in-window value is stored, clears the configuration error, and governs every transition that starts after the load edge.
- R7: A loaded value below the minimum or above the maximum of its direction sets the configuration error and leaves the stored delay unchanged.
- R8: The monitor starts timing at the edge that samples the command differing from the observed status. If the observed change is first seen with fewer than the direction's minimum elapsed edges, the early flag pulses for one cycle.
- R9: If the observed change has not happened by the direction's maximum, the late flag pulses once for that request. A change seen after a late flag raises no early flag.
- R10: A change of the observed status while no request is being timed pulses the early flag. A command of 1 during a timed open ends that timing without a flag.
- R11: The busy output is 1 exactly while a transition is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| cmdClose | input | 1 | Command: 1 close, 0 open |
| cfgLoad | input | 1 | One-cycle strobe to load a delay value |
| cfgSel | input | 1 | Delay selector: 0 close delay, 1 open delay |
| cfgValue | input | CNT_W | Delay value in clock cycles |
| obsStatus | input | 1 | Externally observed contact status for the monitor |
| status | output | 1 | Modelled contact status: 1 closed, 0 open |
| busy | output | 1 | A transition is pending |
| cfgErr | output | 1 | Last load was out of its window |
| monEarly | output | 1 | One-cycle pulse: early or unrequested observed change |
| monLate | output | 1 | One-cycle pulse: observed change overdue |

## Verification
The bench uses a 6-bit delay field with a close window of 2 to 5 and an open window of 3 to 7. These short windows let every delay, the two boundaries of each window and values on both sides of the window be reached in a few dozen cycles. The two windows differ, so a mix-up between the open and close settings shows as a wrong flip cycle. The same bounds make the monitor's late threshold reachable quickly. Its early threshold can be hit with a one-cycle flip, because both minimums are above one.

// File: rtl/contactor_pkg.sv
package contactor_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE    = 2'd0,
    ACT_CLOSING = 2'd1,
    ACT_OPENING = 2'd2
  } actState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCnt;   // load the delay counter from the selected delay register
    logic pickOpen;  // 1 selects the open delay, 0 the close delay
    logic decCnt;    // decrement the delay counter
    logic flip;      // toggle the modelled status
  } dpStrobe_t;

endpackage

// File: rtl/contactor_ctrl.sv
module contactor_ctrl
  import contactor_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdClose,
  input  logic       statusQ,
  input  logic       cntZero,
  output dpStrobe_t  strobe,
  output logic       busy
);

  actState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ACT_IDLE: begin
        if (cmdClose != statusQ) begin
          strobe.loadCnt  = 1'b1;
          strobe.pickOpen = ~cmdClose;
          stateD          = cmdClose ? ACT_CLOSING : ACT_OPENING;
        end
      end
      ACT_CLOSING: begin
        // a started close always completes
        if (cntZero) begin
          strobe.flip = 1'b1;
          stateD      = ACT_IDLE;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ACT_OPENING: begin
        if (cmdClose) begin
          // renewed close abandons the pending open
          stateD = ACT_IDLE;
        end else if (cntZero) begin
          strobe.flip = 1'b1;
          stateD      = ACT_IDLE;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      default: stateD = ACT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ACT_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ACT_IDLE);

endmodule

// File: rtl/contactor_datapath.sv
module contactor_datapath
  import contactor_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int CLOSE_MIN = 2,
  parameter int CLOSE_MAX = 5,
  parameter int OPEN_MIN  = 3,
  parameter int OPEN_MAX  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic             cfgLoad,
  input  logic             cfgSel,
  input  logic [CNT_W-1:0] cfgValue,
  output logic             statusQ,
  output logic             cntZero,
  output logic             cfgErr
);

  localparam int NUM_DIR = 2;  // index 0 close, index 1 open

  logic [NUM_DIR-1:0] inWindow;
  logic [CNT_W-1:0]   delayOf [NUM_DIR];
  logic [CNT_W-1:0]   delayPick;
  logic [CNT_W-1:0]   cntQ;

  for (genvar g = 0; g < NUM_DIR; g++) begin : gDir
    localparam logic [CNT_W-1:0] LO = CNT_W'((g == 0) ? CLOSE_MIN : OPEN_MIN);
    localparam logic [CNT_W-1:0] HI = CNT_W'((g == 0) ? CLOSE_MAX : OPEN_MAX);
    localparam logic             SEL = (g != 0);

    logic [CNT_W-1:0] delayR;

    assign inWindow[g] = (cfgValue >= LO) && (cfgValue <= HI);

    always_ff @(posedge clk) begin
      if (!rstN)
        delayR <= LO;
      else if (cfgLoad && (cfgSel == SEL) && inWindow[g])
        delayR <= cfgValue;
    end

    assign delayOf[g] = delayR;
  end

  assign delayPick = strobe.pickOpen ? delayOf[1] : delayOf[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgErr <= 1'b0;
    end else if (cfgLoad) begin
      cfgErr <= ~inWindow[cfgSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.loadCnt) begin
      cntQ <= delayPick - CNT_W'(1);
    end else if (strobe.decCnt) begin
      cntQ <= cntQ - CNT_W'(1);
    end
  end

  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN)            statusQ <= 1'b0;
    else if (strobe.flip) statusQ <= ~statusQ;
  end

endmodule

// File: rtl/contactor_monitor.sv
module contactor_monitor #(
  parameter int CNT_W     = 6,
  parameter int CLOSE_MIN = 2,
  parameter int CLOSE_MAX = 5,
  parameter int OPEN_MIN  = 3,
  parameter int OPEN_MAX  = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdClose,
  input  logic obsStatus,
  output logic monEarly,
  output logic monLate
);

  localparam logic [CNT_W-1:0] C_LO = CNT_W'(CLOSE_MIN);
  localparam logic [CNT_W-1:0] C_HI = CNT_W'(CLOSE_MAX);
  localparam logic [CNT_W-1:0] O_LO = CNT_W'(OPEN_MIN);
  localparam logic [CNT_W-1:0] O_HI = CNT_W'(OPEN_MAX);

  logic             waitQ;
  logic             targetQ;
  logic [CNT_W-1:0] elapsedQ;
  logic             lateDoneQ;
  logic             prevObsQ;
  logic             obsFlip;
  logic [CNT_W-1:0] minSel;
  logic [CNT_W-1:0] maxSel;

  assign obsFlip = (obsStatus != prevObsQ);
  assign minSel  = targetQ ? C_LO : O_LO;
  assign maxSel  = targetQ ? C_HI : O_HI;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitQ     <= 1'b0;
      targetQ   <= 1'b0;
      elapsedQ  <= '0;
      lateDoneQ <= 1'b0;
      prevObsQ  <= 1'b0;
      monEarly  <= 1'b0;
      monLate   <= 1'b0;
    end else begin
      prevObsQ <= obsStatus;
      monEarly <= 1'b0;
      monLate  <= 1'b0;
      if (waitQ) begin
        if (obsFlip) begin
          if (!lateDoneQ && (elapsedQ < minSel)) monEarly <= 1'b1;
          if (cmdClose != obsStatus) begin
            targetQ   <= cmdClose;
            elapsedQ  <= '0;
            lateDoneQ <= 1'b0;
          end else begin
            waitQ <= 1'b0;
          end
        end else if (!targetQ && cmdClose) begin
          waitQ <= 1'b0;
        end else begin
          if (!lateDoneQ && (elapsedQ >= maxSel)) begin
            monLate   <= 1'b1;
            lateDoneQ <= 1'b1;
          end
          if (elapsedQ != '1) elapsedQ <= elapsedQ + CNT_W'(1);
        end
      end else begin
        if (obsFlip) monEarly <= 1'b1;
        if (cmdClose != obsStatus) begin
          waitQ     <= 1'b1;
          targetQ   <= cmdClose;
          elapsedQ  <= '0;
          lateDoneQ <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/contactor_model.sv
module contactor_model
  import contactor_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int CLOSE_MIN = 2,
  parameter int CLOSE_MAX = 5,
  parameter int OPEN_MIN  = 3,
  parameter int OPEN_MAX  = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdClose,
  input  logic             cfgLoad,
  input  logic             cfgSel,
  input  logic [CNT_W-1:0] cfgValue,
  input  logic             obsStatus,
  output logic             status,
  output logic             busy,
  output logic             cfgErr,
  output logic             monEarly,
  output logic             monLate
);

  dpStrobe_t strobe;
  logic      cntZero;

  contactor_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdClose (cmdClose),
    .statusQ  (status),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .busy     (busy)
  );

  contactor_datapath #(
    .CNT_W(CNT_W), .CLOSE_MIN(CLOSE_MIN), .CLOSE_MAX(CLOSE_MAX),
    .OPEN_MIN(OPEN_MIN), .OPEN_MAX(OPEN_MAX)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgLoad  (cfgLoad),
    .cfgSel   (cfgSel),
    .cfgValue (cfgValue),
    .statusQ  (status),
    .cntZero  (cntZero),
    .cfgErr   (cfgErr)
  );

  contactor_monitor #(
    .CNT_W(CNT_W), .CLOSE_MIN(CLOSE_MIN), .CLOSE_MAX(CLOSE_MAX),
    .OPEN_MIN(OPEN_MIN), .OPEN_MAX(OPEN_MAX)
  ) uMon (
    .clk       (clk),
    .rstN      (rstN),
    .cmdClose  (cmdClose),
    .obsStatus (obsStatus),
    .monEarly  (monEarly),
    .monLate   (monLate)
  );

endmodule

// File: rtl/contactor_model_checker.sv
module contactor_model_checker #(
  parameter int CNT_W     = 6,
  parameter int CLOSE_MIN = 2,
  parameter int CLOSE_MAX = 5,
  parameter int OPEN_MIN  = 3,
  parameter int OPEN_MAX  = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             cmdClose,
  input logic             cfgLoad,
  input logic             cfgSel,
  input logic [CNT_W-1:0] cfgValue,
  input logic             status,
  input logic             busy,
  input logic             cfgErr,
  input logic             monEarly,
  input logic             monLate
);

  localparam int CW = CNT_W + 1;

  // cycles spent busy, counted independently of the datapath counter
  logic [CW-1:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                  busyCnt <= '0;
    else if (!busy)             busyCnt <= '0;
    else if (busyCnt != '1)     busyCnt <= busyCnt + CW'(1);
  end

  logic cfgInWin;
  assign cfgInWin = cfgSel ? (int'(cfgValue) >= OPEN_MIN  && int'(cfgValue) <= OPEN_MAX)
                           : (int'(cfgValue) >= CLOSE_MIN && int'(cfgValue) <= CLOSE_MAX);

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && (cmdClose == status)) |=> $stable(status));

  assert_change_needs_busy_R1: assert property (@(posedge clk) disable iff (!rstN)
    (status != $past(status)) |-> $past(busy));

  assert_close_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status) |-> (int'(busyCnt) >= CLOSE_MIN && int'(busyCnt) <= CLOSE_MAX));

  assert_open_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status) |-> (int'(busyCnt) >= OPEN_MIN && int'(busyCnt) <= OPEN_MAX));

  assert_cancel_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && status && cmdClose) |=> (status && !busy));

  assert_cfg_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && cfgInWin) |=> !cfgErr);

  assert_cfg_reject_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && !cfgInWin) |=> cfgErr);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(monEarly && monLate));

endmodule

bind contactor_model contactor_model_checker #(
  .CNT_W(CNT_W), .CLOSE_MIN(CLOSE_MIN), .CLOSE_MAX(CLOSE_MAX),
  .OPEN_MIN(OPEN_MIN), .OPEN_MAX(OPEN_MAX)
) uChk (
  .clk(clk), .rstN(rstN), .cmdClose(cmdClose), .cfgLoad(cfgLoad),
  .cfgSel(cfgSel), .cfgValue(cfgValue), .status(status), .busy(busy),
  .cfgErr(cfgErr), .monEarly(monEarly), .monLate(monLate)
);

// File: tb/contactor_model_test.sv
`timescale 1ns/1ps
module contactor_model_test;

  localparam int CNT_W = 6;
  localparam int CMIN = 2, CMAX = 5, OMIN = 3, OMAX = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdClose = 1'b0, cfgLoad = 1'b0, cfgSel = 1'b0;
  logic [CNT_W-1:0] cfgValue = '0;
  logic obsFollow = 1'b1, obsManual = 1'b0;
  logic obsStatus;
  logic status, busy, cfgErr, monEarly, monLate;

  always #10 clk = ~clk;  // 50 MHz

  assign obsStatus = obsFollow ? status : obsManual;

  contactor_model #(.CNT_W(CNT_W), .CLOSE_MIN(CMIN), .CLOSE_MAX(CMAX),
                    .OPEN_MIN(OMIN), .OPEN_MAX(OMAX)) uut (
    .clk(clk), .rstN(rstN), .cmdClose(cmdClose), .cfgLoad(cfgLoad),
    .cfgSel(cfgSel), .cfgValue(cfgValue), .obsStatus(obsStatus),
    .status(status), .busy(busy), .cfgErr(cfgErr),
    .monEarly(monEarly), .monLate(monLate));

  int checks = 0, fails = 0;
  int earlySeen = 0, lateSeen = 0;
  bit modelLive = 0;

  // behavioural reference
  int mStatus, mPend, mRem, mCloseD, mOpenD, mErr;      // mPend: 0 none, 1 close, 2 open
  int wWait, wTarget, wElapsed, wLateDone, wPrev, mEarly, mLate;

  always @(posedge clk) begin
    int obsNow, cmd, v, lo, hi;
    cmd = int'(cmdClose);
    if (!rstN) begin
      mStatus = 0; mPend = 0; mRem = 0; mCloseD = CMIN; mOpenD = OMIN; mErr = 0;
      wWait = 0; wTarget = 0; wElapsed = 0; wLateDone = 0; wPrev = 0; mEarly = 0; mLate = 0;
    end else begin
      obsNow = obsFollow ? mStatus : int'(obsManual);
      // monitor
      mEarly = 0; mLate = 0;
      lo = wTarget ? CMIN : OMIN;
      hi = wTarget ? CMAX : OMAX;
      if (wWait != 0) begin
        if (obsNow != wPrev) begin
          if (wLateDone == 0 && wElapsed < lo) mEarly = 1;
          if (cmd != obsNow) begin wTarget = cmd; wElapsed = 0; wLateDone = 0; end
          else wWait = 0;
        end else if (wTarget == 0 && cmd == 1) begin
          wWait = 0;
        end else begin
          if (wLateDone == 0 && wElapsed >= hi) begin mLate = 1; wLateDone = 1; end
          if (wElapsed < (1 << CNT_W) - 1) wElapsed++;
        end
      end else begin
        if (obsNow != wPrev) mEarly = 1;
        if (cmd != obsNow) begin wWait = 1; wTarget = cmd; wElapsed = 0; wLateDone = 0; end
      end
      wPrev = obsNow;
      // actuator
      if (mPend == 0) begin
        if (cmd != mStatus) begin mPend = cmd ? 1 : 2; mRem = cmd ? mCloseD : mOpenD; end
      end else if (mPend == 2 && cmd == 1) begin
        mPend = 0;
      end else begin
        mRem--;
        if (mRem == 0) begin mStatus = 1 - mStatus; mPend = 0; end
      end
      // configuration
      if (cfgLoad) begin
        v = int'(cfgValue);
        lo = cfgSel ? OMIN : CMIN;
        hi = cfgSel ? OMAX : CMAX;
        if (v >= lo && v <= hi) begin
          mErr = 0;
          if (cfgSel) mOpenD = v; else mCloseD = v;
        end else mErr = 1;
      end
    end
    modelLive = 1;
  end

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (modelLive) begin
      cmp("R1 R2 R3 R4 status", int'(status), mStatus);
      cmp("R11 busy", int'(busy), (mPend != 0) ? 1 : 0);
      cmp("R6 R7 cfgErr", int'(cfgErr), mErr);
      cmp("R8 R10 monEarly", int'(monEarly), mEarly);
      cmp("R9 monLate", int'(monLate), mLate);
      if (monEarly) earlySeen++;
      if (monLate) lateSeen++;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input bit sel, input int val);
    cfgSel = sel; cfgValue = CNT_W'(val); cfgLoad = 1'b1;
    tick(1);
    cfgLoad = 1'b0;
  endtask

  int e0, l0;

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R5: reset state
    cmp("R5 status after reset", int'(status), 0);
    cmp("R5 busy after reset", int'(busy), 0);
    cmp("R5 cfgErr after reset", int'(cfgErr), 0);

    // R2: default close delay CMIN
    cmdClose = 1'b1;
    tick(2);
    cmp("R2 status before close delay", int'(status), 0);
    cmp("R11 busy during close", int'(busy), 1);
    tick(1);
    cmp("R2 status at close delay", int'(status), 1);

    // R3: default open delay OMIN
    cmdClose = 1'b0;
    tick(3);
    cmp("R3 status before open delay", int'(status), 1);
    tick(1);
    cmp("R3 status at open delay", int'(status), 0);

    // R6: load close delay at window top
    load(1'b0, CMAX);
    cmp("R6 cfgErr after valid load", int'(cfgErr), 0);
    cmdClose = 1'b1;
    tick(5);
    cmp("R6 status before new close delay", int'(status), 0);
    tick(1);
    cmp("R6 status at new close delay", int'(status), 1);

    // R7: out-of-window loads are refused
    load(1'b0, CMAX + 4);
    cmp("R7 cfgErr above window", int'(cfgErr), 1);
    cmdClose = 1'b0;
    tick(6);
    load(1'b1, OMIN - 2);
    cmp("R7 cfgErr below window", int'(cfgErr), 1);
    cmdClose = 1'b1;
    tick(5);
    cmp("R7 close delay unchanged (still 5)", int'(status), 0);
    tick(1);
    cmp("R7 close delay unchanged flip", int'(status), 1);
    load(1'b1, OMAX);
    cmp("R7 cfgErr cleared by valid load", int'(cfgErr), 0);

    // R4: cancel a pending open
    cmdClose = 1'b0;
    tick(2);
    cmp("R4 open pending", int'(busy), 1);
    cmdClose = 1'b1;
    tick(1);
    cmp("R4 busy dropped after cancel", int'(busy), 0);
    cmp("R4 status stays closed", int'(status), 1);
    tick(10);
    cmp("R4 status still closed", int'(status), 1);

    // R2: a started close is not cancelled
    cmdClose = 1'b0;
    tick(9);
    cmdClose = 1'b1;
    tick(1);
    cmdClose = 1'b0;
    tick(4);
    cmp("R2 committed close not yet done", int'(status), 0);
    tick(1);
    cmp("R2 committed close completes", int'(status), 1);
    tick(10);
    cmp("R3 reopen after committed close", int'(status), 0);

    // R1: hold
    tick(10);
    cmp("R1 status held", int'(status), 0);
    cmp("R1 busy idle", int'(busy), 0);
    cmp("R8 R9 no flags on legal timing", earlySeen + lateSeen, 0);

    // monitor with externally driven status
    obsManual = 1'b0;
    obsFollow = 1'b0;
    tick(2);
    e0 = earlySeen;
    cmdClose = 1'b1;
    tick(1);
    obsManual = 1'b1;   // seen one edge after the request: too soon
    tick(3);
    cmp("R8 early flip flagged", earlySeen - e0, 1);

    e0 = earlySeen; l0 = lateSeen;
    cmdClose = 1'b0;
    tick(12);
    cmp("R9 late flagged once", lateSeen - l0, 1);
    obsManual = 1'b0;
    tick(3);
    cmp("R9 no early after late", earlySeen - e0, 0);

    // on-time observed close
    e0 = earlySeen; l0 = lateSeen;
    cmdClose = 1'b1;
    tick(4);
    obsManual = 1'b1;
    tick(3);
    cmp("R8 on-time flip not flagged", (earlySeen - e0) + (lateSeen - l0), 0);

    // R10: unrequested change while command matches
    tick(5);
    e0 = earlySeen;
    obsManual = 1'b0;
    cmdClose = 1'b0;
    tick(2);
    cmdClose = 1'b1;
    obsManual = 1'b1;
    tick(2);
    obsManual = 1'b0;
    cmdClose = 1'b0;
    tick(2);
    cmp("R10 unrequested flips flagged", (earlySeen - e0 >= 1) ? 1 : 0, 1);
    tick(10);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule